// File: doc/BRIEF.md
# Receive Payload Realigner

This block sits on the receive side of a transaction-layer datapath. Packets arrive on a 64-bit streaming bus that carries two 32-bit dwords per beat. A start strobe marks the first beat. Each packet has a three-dword header, followed by an optional payload. On input, the payload's position depends on address bit 2 of the header. When that bit is set, the first data dword shares the second beat with the last header dword, in the upper half. When it is clear, the upper half of the second beat is an unused gap and the data starts on the third beat.

The block removes that variation. It captures the header and presents all three header dwords on side outputs for the whole packet, together with the first and last byte-enable nibbles. It then re-packs the payload so that payload dword 0 always sits in the low half of the first output beat. A per-dword valid pair shows which halves of each beat carry data. Packet ends are derived from the header length, so no input end strobe is needed.

Both sides use a ready/valid handshake. Downstream stalls propagate back to the input without losing or repeating any dword.

Top module: `rx_payload_realigner`

## Requirements
- R1: When bit 30 of header dword 0 is clear, the packet has no payload. It produces exactly one output beat with out_dv = 2'b00 and both out_sop and out_eop high, whatever the alignment bit.
- R2: When bit 2 of header dword 2 is 0 (aligned input), payload dword k appears in output beat k/2: bits [31:0] if k is even, bits [63:32] if k is odd.
- R3: When bit 2 of header dword 2 is 1 (unaligned input), the payload uses the same output mapping as R2, so payload dword 0 is in bits [31:0] of the first output beat.
- R4: out_dv bit 0 flags the low dword and bit 1 the high dword. Every beat except the last of a packet shows 2'b11. The last beat shows 2'b01 for an odd length and 2'b11 for an even length. 2'b10 never appears.
- R5: A packet with L payload dwords produces exactly ceil(L/2) output beats: nothing is dropped, repeated or added between packets.
- R6: out_sop is high only on the first output beat of a packet, and out_eop only on its last.
- R7: On every output beat of a packet, out_hdr0/1/2 equal that packet's header dwords. out_first_be equals header dword 1 bits [3:0], and out_last_be equals bits [7:4].
- R8: While out_valid is high and out_ready low, the output beat is held unchanged. in_ready is low while an input beat is waiting that the block cannot yet place.
- R9: The payload length in dwords is taken from header dword 0 bits [9:0], where the value 0 means 1024.
- R10: After reset, out_valid is low and in_ready is high.
- R11: Packets presented back to back, with no idle input cycle between them, are all realigned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sop | input | 1 | First header beat of a packet |
| in_data | input | 64 | Two dwords, low dword in [31:0] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 64 | Realigned payload dwords |
| out_dv | output | 2 | Per-dword valid flags |
| out_sop | output | 1 | First output beat of a packet |
| out_eop | output | 1 | Last output beat of a packet |
| out_hdr0 | output | 32 | Header dword 0 |
| out_hdr1 | output | 32 | Header dword 1 |
| out_hdr2 | output | 32 | Header dword 2 |
| out_first_be | output | 4 | Byte enables of the first payload dword |
| out_last_be | output | 4 | Byte enables of the last payload dword |

## Verification
Some properties are checked by assertions on every cycle:
- a stalled output beat stays unchanged;
- the out_dv code is legal, and every non-final beat is full;
- a header-only beat is always both first and last;
- start and end strobes alternate correctly;
- the header stays constant within a packet.

Other properties can only be shown by the bench's scenarios, because they need a model of what went in. These are the exact placement of each payload dword for both alignments, the correct beat count for odd, even, single-dword and 1024-dword lengths, and freedom from loss or repetition under random backpressure across back-to-back packets.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_HDR_A = 2'd0,  // waiting for first header beat
    ST_HDR_B = 2'd1,  // waiting for second header beat
    ST_BODY  = 2'd2,  // payload beats
    ST_TAIL  = 2'd3   // one held dword left to emit
  } rxr_state_e;
endpackage

// File: rtl/rxr_hdr_capture.sv
module rxr_hdr_capture #(
  parameter int DW         = 32,
  parameter int LEN_W      = 10,
  parameter int HAS_PL_BIT = 30,
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [2*DW-1:0]   in_data,
  output logic [DW-1:0]     hdr0,
  output logic [DW-1:0]     hdr1,
  output logic [CNT_W-1:0]  pay_len,
  output logic              has_pl
);
  logic [DW-1:0] hdr0_q, hdr1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr0_q <= '0;
      hdr1_q <= '0;
    end else if (cap_en) begin
      hdr0_q <= in_data[DW-1:0];
      hdr1_q <= in_data[2*DW-1:DW];
    end
  end

  // zero length field encodes the maximum length
  assign pay_len = {(hdr0_q[LEN_W-1:0] == '0), hdr0_q[LEN_W-1:0]};
  assign has_pl  = hdr0_q[HAS_PL_BIT];
  assign hdr0    = hdr0_q;
  assign hdr1    = hdr1_q;
endmodule

// File: rtl/rxr_realign_ctrl.sv
module rxr_realign_ctrl
  import rxr_pkg::*;
#(
  parameter int DW        = 32,
  parameter int LEN_W     = 10,
  parameter int ALIGN_BIT = 2,
  localparam int CNT_W    = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [2*DW-1:0]   in_data,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  pay_len,
  input  logic              has_pl,
  input  logic              ld_ok,
  output logic              cap_en,
  output logic              emit,
  output logic [2*DW-1:0]   emit_data,
  output logic [1:0]        emit_dv,
  output logic              emit_sop,
  output logic              emit_eop,
  output logic [DW-1:0]     emit_hdr2
);
  rxr_state_e       st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [DW-1:0]    hold_q, hold_d;
  logic [DW-1:0]    hdr2_q, hdr2_d;
  logic             mode_q, mode_d;
  logic             first_q, first_d;

  logic [DW-1:0] lo, hi;
  logic          unal_in, one_dw;
  assign lo      = in_data[DW-1:0];
  assign hi      = in_data[2*DW-1:DW];
  assign unal_in = lo[ALIGN_BIT];
  assign one_dw  = (pay_len == CNT_W'(1));

  always_comb begin
    st_d      = st_q;
    rem_d     = rem_q;
    hold_d    = hold_q;
    hdr2_d    = hdr2_q;
    mode_d    = mode_q;
    first_d   = first_q;
    in_ready  = 1'b0;
    cap_en    = 1'b0;
    emit      = 1'b0;
    emit_data = '0;
    emit_dv   = 2'b00;
    emit_sop  = 1'b0;
    emit_eop  = 1'b0;
    case (st_q)
      ST_HDR_A: begin
        in_ready = 1'b1;
        if (in_valid && in_sop) begin
          cap_en = 1'b1;
          st_d   = ST_HDR_B;
        end
      end
      ST_HDR_B: begin
        in_ready = (!has_pl || (unal_in && one_dw)) ? ld_ok : 1'b1;
        if (in_valid && in_ready) begin
          hdr2_d  = lo;
          mode_d  = unal_in;
          first_d = 1'b1;
          if (!has_pl) begin
            emit     = 1'b1;
            emit_sop = 1'b1;
            emit_eop = 1'b1;
            st_d     = ST_HDR_A;
          end else if (unal_in) begin
            if (one_dw) begin
              emit      = 1'b1;
              emit_data = {{DW{1'b0}}, hi};
              emit_dv   = 2'b01;
              emit_sop  = 1'b1;
              emit_eop  = 1'b1;
              st_d      = ST_HDR_A;
            end else begin
              hold_d = hi;
              rem_d  = pay_len - CNT_W'(1);
              st_d   = ST_BODY;
            end
          end else begin
            rem_d = pay_len;
            st_d  = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        in_ready = ld_ok;
        if (in_valid && ld_ok) begin
          emit     = 1'b1;
          emit_sop = first_q;
          first_d  = 1'b0;
          if (!mode_q) begin
            emit_data = in_data;
            if (rem_q <= CNT_W'(2)) begin
              emit_dv  = (rem_q == CNT_W'(1)) ? 2'b01 : 2'b11;
              emit_eop = 1'b1;
              st_d     = ST_HDR_A;
            end else begin
              emit_dv = 2'b11;
              rem_d   = rem_q - CNT_W'(2);
            end
          end else begin
            emit_data = {lo, hold_q};
            emit_dv   = 2'b11;
            if (rem_q == CNT_W'(1)) begin
              emit_eop = 1'b1;
              st_d     = ST_HDR_A;
            end else begin
              hold_d = hi;
              rem_d  = rem_q - CNT_W'(2);
              if (rem_q == CNT_W'(2)) st_d = ST_TAIL;
            end
          end
        end
      end
      ST_TAIL: begin
        if (ld_ok) begin
          emit      = 1'b1;
          emit_data = {{DW{1'b0}}, hold_q};
          emit_dv   = 2'b01;
          emit_eop  = 1'b1;
          st_d      = ST_HDR_A;
        end
      end
      default: st_d = ST_HDR_A;
    endcase
  end

  assign emit_hdr2 = (st_q == ST_HDR_B) ? lo : hdr2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HDR_A;
      rem_q   <= '0;
      hold_q  <= '0;
      hdr2_q  <= '0;
      mode_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rem_q   <= rem_d;
      hold_q  <= hold_d;
      hdr2_q  <= hdr2_d;
      mode_q  <= mode_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/rxr_out_stage.sv
module rxr_out_stage #(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic [2*DW-1:0]  emit_data,
  input  logic [1:0]       emit_dv,
  input  logic             emit_sop,
  input  logic             emit_eop,
  input  logic [DW-1:0]    hdr0,
  input  logic [DW-1:0]    hdr1,
  input  logic [DW-1:0]    hdr2,
  input  logic             out_ready,
  output logic             ld_ok,
  output logic             out_valid,
  output logic [2*DW-1:0]  out_data,
  output logic [1:0]       out_dv,
  output logic             out_sop,
  output logic             out_eop,
  output logic [DW-1:0]    out_hdr0,
  output logic [DW-1:0]    out_hdr1,
  output logic [DW-1:0]    out_hdr2
);
  logic valid_q, valid_d;

  assign ld_ok = !valid_q || out_ready;

  always_comb begin
    valid_d = valid_q;
    if (emit)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_dv   <= 2'b00;
      out_sop  <= 1'b0;
      out_eop  <= 1'b0;
      out_hdr0 <= '0;
      out_hdr1 <= '0;
      out_hdr2 <= '0;
    end else if (emit) begin
      out_data <= emit_data;
      out_dv   <= emit_dv;
      out_sop  <= emit_sop;
      out_eop  <= emit_eop;
      out_hdr0 <= hdr0;
      out_hdr1 <= hdr1;
      out_hdr2 <= hdr2;
    end
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/rx_payload_realigner.sv
module rx_payload_realigner #(
  parameter int DW         = 32,
  parameter int LEN_W      = 10,
  parameter int HAS_PL_BIT = 30,
  parameter int ALIGN_BIT  = 2,
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic [2*DW-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*DW-1:0]  out_data,
  output logic [1:0]       out_dv,
  output logic             out_sop,
  output logic             out_eop,
  output logic [DW-1:0]    out_hdr0,
  output logic [DW-1:0]    out_hdr1,
  output logic [DW-1:0]    out_hdr2,
  output logic [3:0]       out_first_be,
  output logic [3:0]       out_last_be
);
  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic             cap_en, has_pl, ld_ok, emit, emit_sop, emit_eop;
  logic [CNT_W-1:0] pay_len;
  logic [DW-1:0]    hdr0, hdr1, emit_hdr2;
  logic [2*DW-1:0]  emit_data;
  logic [1:0]       emit_dv;

  rxr_hdr_capture #(.DW(DW), .LEN_W(LEN_W), .HAS_PL_BIT(HAS_PL_BIT)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .in_data(in_data),
    .hdr0(hdr0), .hdr1(hdr1), .pay_len(pay_len), .has_pl(has_pl)
  );

  rxr_realign_ctrl #(.DW(DW), .LEN_W(LEN_W), .ALIGN_BIT(ALIGN_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .in_ready(in_ready), .pay_len(pay_len),
    .has_pl(has_pl), .ld_ok(ld_ok), .cap_en(cap_en), .emit(emit),
    .emit_data(emit_data), .emit_dv(emit_dv), .emit_sop(emit_sop),
    .emit_eop(emit_eop), .emit_hdr2(emit_hdr2)
  );

  rxr_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .emit_data(emit_data),
    .emit_dv(emit_dv), .emit_sop(emit_sop), .emit_eop(emit_eop),
    .hdr0(hdr0), .hdr1(hdr1), .hdr2(emit_hdr2), .out_ready(out_ready),
    .ld_ok(ld_ok), .out_valid(out_valid), .out_data(out_data),
    .out_dv(out_dv), .out_sop(out_sop), .out_eop(out_eop),
    .out_hdr0(out_hdr0), .out_hdr1(out_hdr1), .out_hdr2(out_hdr2)
  );

  assign out_first_be = out_hdr1[3:0];
  assign out_last_be  = out_hdr1[7:4];
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2*DW-1:0] out_data,
  input logic [1:0]      out_dv,
  input logic            out_sop,
  input logic            out_eop,
  input logic [DW-1:0]   out_hdr0
);
  // open_q: a packet has started on the output and not yet ended
  logic          open_q;
  logic [DW-1:0] last_h0_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      last_h0_q <= '0;
    end else if (out_valid && out_ready) begin
      open_q    <= !out_eop;
      last_h0_q <= out_hdr0;
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_dv) && $stable(out_sop) && $stable(out_eop));

  p_dv_legal_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> out_dv != 2'b10);

  p_mid_full_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && !out_eop |-> out_dv == 2'b11);

  p_hdr_only_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && out_dv == 2'b00 |-> out_sop && out_eop);

  p_sop_frame_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> out_sop == !open_q);

  p_hdr_stable_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && open_q |-> out_hdr0 == last_h0_q);
endmodule

bind rx_payload_realigner rxr_checker #(.DW(DW)) u_rxr_chk (
  .clk(clk), .rst_ni(rst_ni), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_dv(out_dv), .out_sop(out_sop),
  .out_eop(out_eop), .out_hdr0(out_hdr0)
);

// File: tb/rx_payload_realigner_tb_top.sv
module rx_payload_realigner_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_sop, out_eop;
  logic [63:0] out_data;
  logic [1:0]  out_dv;
  logic [31:0] out_hdr0, out_hdr1, out_hdr2;
  logic [3:0]  out_first_be, out_last_be;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_payload_realigner dut_i (
    .clk(clk), .rst_ni(rst_ni), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_dv(out_dv),
    .out_sop(out_sop), .out_eop(out_eop), .out_hdr0(out_hdr0),
    .out_hdr1(out_hdr1), .out_hdr2(out_hdr2),
    .out_first_be(out_first_be), .out_last_be(out_last_be)
  );

  // vector: {backpressure, unaligned, has_payload, length[10:0]}
  localparam int NV = 16;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 1'b0, 11'd0},    // R1 header only, aligned
    {1'b0, 1'b1, 1'b0, 11'd0},    // R1 header only, alignment bit set
    {1'b0, 1'b0, 1'b1, 11'd1},    // R2 one dword
    {1'b0, 1'b1, 1'b1, 11'd1},    // R3 one dword
    {1'b0, 1'b0, 1'b1, 11'd2},
    {1'b0, 1'b1, 1'b1, 11'd2},
    {1'b0, 1'b0, 1'b1, 11'd3},
    {1'b0, 1'b1, 1'b1, 11'd3},    // extra tail beat
    {1'b0, 1'b1, 1'b1, 11'd4},
    {1'b1, 1'b0, 1'b1, 11'd7},
    {1'b1, 1'b1, 1'b1, 11'd7},
    {1'b1, 1'b1, 1'b1, 11'd8},
    {1'b1, 1'b1, 1'b1, 11'd5},
    {1'b1, 1'b1, 1'b1, 11'd1},
    {1'b1, 1'b0, 1'b0, 11'd0},
    {1'b1, 1'b1, 1'b1, 11'd1024}  // R9 length field zero
  };

  function automatic logic [31:0] dw_val(int p, int k);
    return {8'(p), 8'hD0, 16'(k)};
  endfunction

  function automatic logic [31:0] mk_h0(int p, logic [13:0] v);
    return (v[11] ? 32'h4000_0000 : 32'h0) | (32'(p & 8'hFF) << 16) | 32'(v[9:0]);
  endfunction

  function automatic logic [31:0] mk_h1(int p);
    logic [3:0] fbe = 4'(p) ^ 4'hE;
    logic [3:0] lbe = 4'(p + 1);
    return {16'h0, 8'(p), lbe, fbe};
  endfunction

  function automatic logic [31:0] mk_h2(int p, logic [13:0] v);
    return {8'(p), 20'h0, 1'b0, v[12], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_beat(input logic [63:0] d, input logic sop);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_sop   = sop;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic drv_pkt(input int p, input logic [13:0] v);
    int len = int'(v[10:0]);
    int k;
    send_beat({mk_h1(p), mk_h0(p, v)}, 1'b1);
    if (!v[11]) begin
      send_beat({32'h0, mk_h2(p, v)}, 1'b0);
    end else begin
      k = v[12] ? 1 : 0;
      send_beat({v[12] ? dw_val(p, 0) : 32'h0, mk_h2(p, v)}, 1'b0);
      while (k < len) begin
        send_beat({(k + 1 < len) ? dw_val(p, k + 1) : 32'h0, dw_val(p, k)}, 1'b0);
        k += 2;
      end
    end
  endtask

  task automatic mon_pkt(input int p, input logic [13:0] v);
    int len = int'(v[10:0]);
    int nb = v[11] ? (len + 1) / 2 : 1;
    int j = 0;
    string tg = !v[11] ? "R1" : (len == 1024) ? "R9" : v[12] ? "R3" : "R2";
    logic [1:0] edv;
    while (j < nb) begin
      @(negedge clk);
      out_ready = v[13] ? (($urandom % 4) != 0) : 1'b1;
      #2;
      if (out_valid && out_ready) begin
        if (!v[11]) edv = 2'b00;
        else if (2 * j + 1 < len) edv = 2'b11;
        else edv = 2'b01;
        chk(out_sop == (j == 0), "R6 sop", 64'(out_sop), 64'(j == 0));
        chk(out_eop == (j == nb - 1), "R6 eop", 64'(out_eop), 64'(j == nb - 1));
        chk(out_dv == edv, "R4 dv", 64'(out_dv), 64'(edv));
        if (edv[0])
          chk(out_data[31:0] == dw_val(p, 2 * j), tg, 64'(out_data[31:0]), 64'(dw_val(p, 2 * j)));
        if (edv[1])
          chk(out_data[63:32] == dw_val(p, 2 * j + 1), tg, 64'(out_data[63:32]), 64'(dw_val(p, 2 * j + 1)));
        chk(out_hdr0 == mk_h0(p, v) && out_hdr1 == mk_h1(p) && out_hdr2 == mk_h2(p, v),
            "R7 hdr", {out_hdr1, out_hdr0}, {mk_h1(p), mk_h0(p, v)});
        chk(out_first_be == mk_h1(p)[3:0] && out_last_be == mk_h1(p)[7:4], "R7 be",
            64'({out_last_be, out_first_be}), 64'(mk_h1(p)[7:0]));
        j++;
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [63:0] held;
    logic [13:0] sv;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'(0));
    chk(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'(1));

    // table walk, inputs back to back (R11)
    fork
      begin
        for (int i = 0; i < NV; i++) drv_pkt(i, VEC[i]);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop = 1'b0;
      end
      begin
        for (int i = 0; i < NV; i++) mon_pkt(i, VEC[i]);
      end
    join

    // R8 directed stall: unaligned length 4, output held while blocked
    sv = {1'b0, 1'b1, 1'b1, 11'd4};
    fork
      drv_pkt(16, sv);
      begin
        do begin
          @(negedge clk);
          out_ready = 1'b0;
          #2;
        end while (!out_valid);
        held = out_data;
        for (int c = 0; c < 4; c++) begin
          @(negedge clk);
          #2;
          chk(out_valid == 1'b1 && out_data == held, "R8 hold", out_data, held);
          chk(in_ready == 1'b0, "R8 in_ready", 64'(in_ready), 64'(0));
        end
        mon_pkt(16, sv);
      end
    join
    @(negedge clk);
    in_valid = 1'b0;
    in_sop = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R5 nothing left over after the last packet
    chk(out_valid == 1'b0, "R5 no extra beat", 64'(out_valid), 64'(0));
    done = 1'b1;
    finish_run();
  end
endmodule